// File: doc/BRIEF.md
# Waterfilling CTA Partition Engine

This block decides how a single shader core is divided among several kernels that run at the same time. Each kernel can place some number of thread blocks (CTAs) on the core. For every kernel, and for every CTA count from 0 to the per-core cap, a table holds the normalized throughput that the kernel reached at that count. The table is filled through a write port while cores are sampled at stepped CTA counts. Each kernel also declares how much of the core's resources one of its CTAs occupies, and software supplies the total resource budget of a core.

After a `start` pulse, the engine first gives each kernel one CTA, in index order, as long as that CTA fits. It then runs a greedy waterfilling loop that handles one grant per clock cycle. A parallel minimum search picks the eligible kernel whose throughput at its current count is lowest, and that kernel receives one more CTA. A kernel stops being eligible once its next CTA would exceed the remaining budget, or once the core has reached its CTA cap. A kernel that has dropped out is not considered again in that run.

When no kernel can take another CTA, the engine adds up the throughputs at the final counts and compares the sum with a programmable threshold. If the sum is above the threshold, the flag selects intra-core sharing. Otherwise the flag selects a whole-core spatial split. The final counts are held on the outputs and steer all later CTA dispatch. `done` pulses for one cycle to mark that the counts are ready.

Top module: `wf_partition_engine`

## Requirements
- R1: Out of reset, every CTA count is 0, and `busy`, `done` and `intra_share` are all 0.
- R2: A table write with `tbl_we` high stores `tbl_perf` as the throughput of kernel `tbl_kern` at CTA count `tbl_cnt`. Later partitions use the stored value.
- R3: The first step goes through the kernels from index 0 upward. A kernel gets one CTA if its per-CTA resource fits in the budget not yet used and the core is below the CTA cap. A kernel that does not fit stays at 0 CTAs and is excluded for the rest of the run.
- R4: Each loop iteration grants exactly one CTA. It goes to the eligible kernel with the lowest throughput at its current count, and a tie goes to the lowest kernel index.
- R5: The sum, over all kernels, of CTA count times per-CTA resource never exceeds `res_budget`.
- R6: The total number of granted CTAs never exceeds the cap `MAX_CTA`.
- R7: The loop ends only when no granted kernel could take one more CTA: either the total is at the cap, or every kernel's next CTA would overflow the budget.
- R8: `intra_share` is 1 when the sum of the throughputs at the final nonzero counts is strictly greater than `share_thresh`. It is 0 (spatial split) when the sum is equal or lower.
- R9: `done` is high for exactly one cycle per run. The final counts and `intra_share` stay stable until the next accepted `start`.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the run in progress or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Throughput table write enable |
| tbl_kern | input | KW | Kernel index of the table write |
| tbl_cnt | input | CW | CTA count of the table write (0..MAX_CTA) |
| tbl_perf | input | PERF_W | Normalized throughput to store |
| kern_res | input | NUM_KERN*RES_W | Per-CTA resource need of each kernel, kernel 0 in the low bits |
| res_budget | input | RES_W+CW | Total resource budget of one core |
| share_thresh | input | SW | Threshold for choosing intra-core sharing |
| start | input | 1 | Begin a partition run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: final counts are valid |
| intra_share | output | 1 | 1 = intra-core sharing, 0 = spatial split |
| cta_cnt | output | NUM_KERN*CW | Final CTA count per kernel, kernel 0 in the low bits |

## Verification
The engine is run with rising, offset and flat throughput curves. Rising and offset curves show whether the lowest-throughput kernel wins each step. Flat curves produce constant ties and show that the lowest-index rule holds. A tight budget in which one kernel's CTA never fits separates exclusion during the first step from exclusion inside the loop, while a large budget makes the CTA cap the limit that ends the run. The threshold is placed exactly at the final sum and then one below it, and a single table entry is rewritten between runs to show that a changed curve changes the split.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_ITER = 2'd2,
    ST_SUM  = 2'd3
  } wf_state_e;
endpackage

// File: rtl/wf_perf_table.sv
module wf_perf_table #(
  parameter int NUM_KERN = 3,
  parameter int MAX_CTA  = 8,
  parameter int PERF_W   = 8,
  parameter int CW       = 4,
  parameter int KW       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [KW-1:0]            wr_kern,
  input  logic [CW-1:0]            wr_cnt,
  input  logic [PERF_W-1:0]        wr_perf,
  input  logic [NUM_KERN*CW-1:0]   rd_cnt,
  output logic [NUM_KERN*PERF_W-1:0] rd_perf
);
  localparam int DEPTH = MAX_CTA + 1;

  logic [PERF_W-1:0] mem_q [NUM_KERN][DEPTH];

  for (genvar gk = 0; gk < NUM_KERN; gk++) begin : g_kern
    for (genvar gc = 0; gc < DEPTH; gc++) begin : g_cnt
      logic ent_en;
      assign ent_en = wr_en && (int'(wr_kern) == gk) && (int'(wr_cnt) == gc);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[gk][gc] <= '0;
        end else if (ent_en) begin
          mem_q[gk][gc] <= wr_perf;
        end
      end
    end

    logic [CW-1:0] sel_cnt;
    assign sel_cnt = rd_cnt[gk*CW +: CW];
    always_comb begin
      rd_perf[gk*PERF_W +: PERF_W] = '0;
      for (int c = 0; c < DEPTH; c++) begin
        if (int'(sel_cnt) == c) rd_perf[gk*PERF_W +: PERF_W] = mem_q[gk][c];
      end
    end
  end
endmodule

// File: rtl/wf_elig.sv
module wf_elig #(
  parameter int NUM_KERN = 3,
  parameter int MAX_CTA  = 8,
  parameter int RES_W    = 10,
  parameter int CW       = 4,
  parameter int UW       = 14
) (
  input  logic [UW-1:0]             used_res,
  input  logic [UW-1:0]             budget,
  input  logic [CW-1:0]             total,
  input  logic [NUM_KERN*RES_W-1:0] kern_res,
  input  logic [NUM_KERN-1:0]       active,
  output logic [NUM_KERN-1:0]       elig
);
  localparam logic [CW-1:0] CAP = CW'(MAX_CTA);

  logic below_cap;
  assign below_cap = (total < CAP);

  for (genvar gk = 0; gk < NUM_KERN; gk++) begin : g_fit
    logic [UW:0] need;
    logic        fits;
    assign need = {1'b0, used_res} + (UW+1)'(kern_res[gk*RES_W +: RES_W]);
    assign fits = (need <= {1'b0, budget});
    assign elig[gk] = active[gk] && fits && below_cap;
  end
endmodule

// File: rtl/wf_min_sel.sv
module wf_min_sel #(
  parameter int NUM_KERN = 3,
  parameter int PERF_W   = 8,
  parameter int KW       = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_KERN*PERF_W-1:0] perf,
  input  logic [NUM_KERN-1:0]        cand,
  output logic                       found,
  output logic [KW-1:0]              win_idx,
  output logic [NUM_KERN-1:0]        win_oh
);
  logic [PERF_W-1:0] best_perf;

  always_comb begin
    found     = 1'b0;
    win_idx   = '0;
    best_perf = '0;
    for (int k = 0; k < NUM_KERN; k++) begin
      if (cand[k] && (!found || (perf[k*PERF_W +: PERF_W] < best_perf))) begin
        found     = 1'b1;
        win_idx   = KW'(k);
        best_perf = perf[k*PERF_W +: PERF_W];
      end
    end
    win_oh = '0;
    if (found) win_oh[win_idx] = 1'b1;
  end

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh)); // R4
  AST_WIN_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((win_oh & ~cand) == '0)); // R4
endmodule

// File: rtl/wf_partition_engine.sv
module wf_partition_engine #(
  parameter int NUM_KERN = 3,
  parameter int MAX_CTA  = 8,
  parameter int PERF_W   = 8,
  parameter int RES_W    = 10,
  localparam int CW      = $clog2(MAX_CTA + 1),
  localparam int KW      = (NUM_KERN > 1) ? $clog2(NUM_KERN) : 1,
  localparam int UW      = RES_W + CW,
  localparam int SW      = PERF_W + $clog2(NUM_KERN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tbl_we,
  input  logic [KW-1:0]              tbl_kern,
  input  logic [CW-1:0]              tbl_cnt,
  input  logic [PERF_W-1:0]          tbl_perf,
  input  logic [NUM_KERN*RES_W-1:0]  kern_res,
  input  logic [UW-1:0]              res_budget,
  input  logic [SW-1:0]              share_thresh,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  output logic                       intra_share,
  output logic [NUM_KERN*CW-1:0]     cta_cnt
);
  import wf_pkg::*;

  localparam logic [KW-1:0] LAST_K = KW'(NUM_KERN - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_ni;
  assign rst_ni = rst_s2_q;

  wf_state_e             state_q, state_d;
  logic [KW-1:0]         idx_q, idx_d;
  logic [CW-1:0]         cnt_q [NUM_KERN];
  logic [CW-1:0]         cnt_d [NUM_KERN];
  logic [UW-1:0]         used_q, used_d;
  logic [CW-1:0]         total_q, total_d;
  logic [NUM_KERN-1:0]   active_q, active_d;
  logic                  done_q, done_d;
  logic                  intra_q, intra_d;
  logic                  upd_en;

  logic [NUM_KERN*CW-1:0]     cnt_flat;
  logic [NUM_KERN*PERF_W-1:0] cur_perf;
  logic [NUM_KERN-1:0]        elig;
  logic                       found;
  logic [KW-1:0]              win_idx;
  logic [NUM_KERN-1:0]        win_oh;
  logic [SW-1:0]              perf_sum;

  for (genvar gk = 0; gk < NUM_KERN; gk++) begin : g_flat
    assign cnt_flat[gk*CW +: CW] = cnt_q[gk];
  end

  wf_perf_table #(
    .NUM_KERN(NUM_KERN), .MAX_CTA(MAX_CTA), .PERF_W(PERF_W), .CW(CW), .KW(KW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (tbl_we),
    .wr_kern (tbl_kern),
    .wr_cnt  (tbl_cnt),
    .wr_perf (tbl_perf),
    .rd_cnt  (cnt_flat),
    .rd_perf (cur_perf)
  );

  wf_elig #(
    .NUM_KERN(NUM_KERN), .MAX_CTA(MAX_CTA), .RES_W(RES_W), .CW(CW), .UW(UW)
  ) u_elig (
    .used_res (used_q),
    .budget   (res_budget),
    .total    (total_q),
    .kern_res (kern_res),
    .active   (active_q),
    .elig     (elig)
  );

  wf_min_sel #(
    .NUM_KERN(NUM_KERN), .PERF_W(PERF_W), .KW(KW)
  ) u_min (
    .clk     (clk),
    .rst_n   (rst_ni),
    .perf    (cur_perf),
    .cand    (elig),
    .found   (found),
    .win_idx (win_idx),
    .win_oh  (win_oh)
  );

  // throughput sum over kernels holding at least one CTA
  always_comb begin
    perf_sum = '0;
    for (int k = 0; k < NUM_KERN; k++) begin
      if (cnt_q[k] != '0) perf_sum = perf_sum + SW'(cur_perf[k*PERF_W +: PERF_W]);
    end
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    used_d   = used_q;
    total_d  = total_q;
    active_d = active_q;
    done_d   = 1'b0;
    intra_d  = intra_q;
    upd_en   = 1'b0;
    for (int k = 0; k < NUM_KERN; k++) cnt_d[k] = cnt_q[k];

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          upd_en   = 1'b1;
          state_d  = ST_INIT;
          idx_d    = '0;
          used_d   = '0;
          total_d  = '0;
          active_d = '1;
          intra_d  = 1'b0;
          for (int k = 0; k < NUM_KERN; k++) cnt_d[k] = '0;
        end
      end
      ST_INIT: begin
        upd_en = 1'b1;
        if (elig[idx_q]) begin
          cnt_d[idx_q] = CW'(1);
          used_d       = used_q + UW'(kern_res[idx_q*RES_W +: RES_W]);
          total_d      = total_q + CW'(1);
        end else begin
          active_d[idx_q] = 1'b0;
        end
        if (idx_q == LAST_K) state_d = ST_ITER;
        else                 idx_d   = idx_q + KW'(1);
      end
      ST_ITER: begin
        upd_en = 1'b1;
        if (found) begin
          cnt_d[win_idx] = cnt_q[win_idx] + CW'(1);
          used_d         = used_q + UW'(kern_res[win_idx*RES_W +: RES_W]);
          total_d        = total_q + CW'(1);
          active_d       = active_q & elig;
        end else begin
          state_d = ST_SUM;
        end
      end
      ST_SUM: begin
        upd_en  = 1'b1;
        intra_d = (perf_sum > share_thresh);
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      used_q   <= '0;
      total_q  <= '0;
      active_q <= '0;
      done_q   <= 1'b0;
      intra_q  <= 1'b0;
      for (int k = 0; k < NUM_KERN; k++) cnt_q[k] <= '0;
    end else begin
      done_q <= done_d;
      if (upd_en) begin
        state_q  <= state_d;
        idx_q    <= idx_d;
        used_q   <= used_d;
        total_q  <= total_d;
        active_q <= active_d;
        intra_q  <= intra_d;
        for (int k = 0; k < NUM_KERN; k++) cnt_q[k] <= cnt_d[k];
      end
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign intra_share = intra_q;
  assign cta_cnt     = cnt_flat;

  AST_BUDGET_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (used_q <= res_budget)); // R5
  AST_CTA_CAP: assert property (@(posedge clk) disable iff (!rst_ni)
    total_q <= CW'(MAX_CTA)); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_ITER && found) |=> (total_q == $past(total_q) + CW'(1))); // R4
  AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_ITER && found) |-> elig[win_idx]); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && !start) |=> $stable(cta_cnt) && $stable(intra_share)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_SUM && start) |=> busy); // R10
endmodule

// File: tb/tb_wf_partition_engine.sv
module tb_wf_partition_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NK   = 3;
  localparam int NMAX = 8;
  localparam int PW   = 8;
  localparam int RW   = 10;
  localparam int CW   = $clog2(NMAX + 1);
  localparam int KW   = 2;
  localparam int UW   = RW + CW;
  localparam int SW   = PW + $clog2(NK + 1);

  logic clk, rst_n;
  logic tbl_we;
  logic [KW-1:0] tbl_kern;
  logic [CW-1:0] tbl_cnt;
  logic [PW-1:0] tbl_perf;
  logic [NK*RW-1:0] kern_res;
  logic [UW-1:0] res_budget;
  logic [SW-1:0] share_thresh;
  logic start, busy, done, intra_share;
  logic [NK*CW-1:0] cta_cnt;

  wf_partition_engine #(.NUM_KERN(NK), .MAX_CTA(NMAX), .PERF_W(PW), .RES_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_kern(tbl_kern), .tbl_cnt(tbl_cnt),
    .tbl_perf(tbl_perf), .kern_res(kern_res), .res_budget(res_budget),
    .share_thresh(share_thresh), .start(start), .busy(busy), .done(done),
    .intra_share(intra_share), .cta_cnt(cta_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit reported = 0;

  int tb_tbl [NK][NMAX+1];
  int tb_res [NK];
  int tb_budget;
  int tb_thr;
  int exp_cnt [NK];
  bit exp_intra;
  int exp_sum;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic int dut_cnt(input int k);
    return int'(cta_cnt[k*CW +: CW]);
  endfunction

  // reference from the requirements
  task automatic model();
    int used, tot, best, guard;
    bit act [NK];
    used = 0; tot = 0;
    for (int k = 0; k < NK; k++) begin exp_cnt[k] = 0; act[k] = 1; end
    for (int k = 0; k < NK; k++) begin
      if (used + tb_res[k] <= tb_budget && tot < NMAX) begin
        exp_cnt[k] = 1; used += tb_res[k]; tot++;
      end else act[k] = 0;
    end
    guard = 0;
    while (guard < 100) begin
      guard++;
      best = -1;
      for (int k = 0; k < NK; k++) begin
        if (act[k] && used + tb_res[k] <= tb_budget && tot < NMAX) begin
          if (best < 0 || tb_tbl[k][exp_cnt[k]] < tb_tbl[best][exp_cnt[best]]) best = k;
        end else act[k] = 0;
      end
      if (best < 0) break;
      exp_cnt[best]++; used += tb_res[best]; tot++;
    end
    exp_sum = 0;
    for (int k = 0; k < NK; k++) if (exp_cnt[k] > 0) exp_sum += tb_tbl[k][exp_cnt[k]];
    exp_intra = (exp_sum > tb_thr);
  endtask

  task automatic wr_entry(input int k, input int c, input int p);
    @(negedge clk);
    tbl_we = 1; tbl_kern = KW'(k); tbl_cnt = CW'(c); tbl_perf = PW'(p);
    tb_tbl[k][c] = p;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic set_cfg(input int r0, input int r1, input int r2, input int bud, input int thr);
    tb_res[0] = r0; tb_res[1] = r1; tb_res[2] = r2; tb_budget = bud; tb_thr = thr;
    kern_res = {RW'(r2), RW'(r1), RW'(r0)};
    res_budget = UW'(bud);
    share_thresh = SW'(thr);
  endtask

  task automatic run_engine(input bit restart_mid, output bit got);
    int waited;
    got = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (restart_mid) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    waited = 0;
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    got = done;
  endtask

  task automatic check_result(input string tag);
    int used, tot;
    bit any_fit;
    model();
    for (int k = 0; k < NK; k++)
      check(dut_cnt(k) == exp_cnt[k], tag, dut_cnt(k), exp_cnt[k]);
    check(intra_share == exp_intra, {tag, " R8"}, int'(intra_share), int'(exp_intra));
    used = 0; tot = 0;
    for (int k = 0; k < NK; k++) begin used += dut_cnt(k) * tb_res[k]; tot += dut_cnt(k); end
    check(used <= tb_budget, "R5 budget", used, tb_budget);
    check(tot <= NMAX, "R6 cap", tot, NMAX);
    any_fit = 0;
    for (int k = 0; k < NK; k++)
      if (dut_cnt(k) > 0 && tot < NMAX && used + tb_res[k] <= tb_budget) any_fit = 1;
    check(!any_fit, "R7 loop end", int'(any_fit), 0);
    @(negedge clk);
    check(done == 0, "R9 done pulse", int'(done), 0);
    check(busy == 0, "R9 idle", int'(busy), 0);
    repeat (3) @(negedge clk);
    for (int k = 0; k < NK; k++)
      check(dut_cnt(k) == exp_cnt[k], "R9 hold", dut_cnt(k), exp_cnt[k]);
  endtask

  task automatic load_curves(input int mode);
    for (int k = 0; k < NK; k++)
      for (int c = 0; c <= NMAX; c++) begin
        int p;
        if (mode == 0) p = (k == 0) ? 10*c : (k == 1) ? 5*c + 20 : 30 + 2*c;
        else           p = 50;
        wr_entry(k, c, p);
      end
  endtask

  task automatic t_reset();
    check(busy == 0, "R1 busy", int'(busy), 0);
    check(done == 0, "R1 done", int'(done), 0);
    check(intra_share == 0, "R1 intra", int'(intra_share), 0);
    for (int k = 0; k < NK; k++) check(dut_cnt(k) == 0, "R1 count", dut_cnt(k), 0);
  endtask

  task automatic t_rising_cap();
    bit got;
    load_curves(0);
    set_cfg(1, 1, 1, 100, 60);
    run_engine(0, got);
    check(got, "R9 done seen", int'(got), 1);
    check_result("R4 R6 rising");
  endtask

  task automatic t_tie();
    bit got;
    load_curves(1);
    set_cfg(1, 1, 1, 100, 100);
    run_engine(0, got);
    check(got, "R9 done seen", int'(got), 1);
    check(dut_cnt(0) == 6, "R4 tie low index", dut_cnt(0), 6);
    check_result("R4 tie");
  endtask

  task automatic t_budget();
    bit got;
    load_curves(0);
    set_cfg(4, 3, 9, 12, 10);
    run_engine(0, got);
    check(got, "R9 done seen", int'(got), 1);
    check(dut_cnt(2) == 0, "R3 excluded", dut_cnt(2), 0);
    check_result("R3 R5 budget");
  endtask

  task automatic t_thresh();
    bit got;
    load_curves(0);
    set_cfg(2, 1, 3, 20, 0);
    model();
    set_cfg(2, 1, 3, 20, exp_sum);
    run_engine(0, got);
    check(intra_share == 0, "R8 equal thresh", int'(intra_share), 0);
    check_result("R8 eq");
    set_cfg(2, 1, 3, 20, exp_sum - 1);
    run_engine(0, got);
    check(intra_share == 1, "R8 above thresh", int'(intra_share), 1);
    check_result("R8 above");
  endtask

  task automatic t_rewrite();
    bit got;
    load_curves(1);
    set_cfg(1, 1, 1, 100, 100);
    wr_entry(0, 1, 90);
    run_engine(0, got);
    check(dut_cnt(1) == 6, "R2 rewrite moves grants", dut_cnt(1), 6);
    check_result("R2 rewrite");
  endtask

  task automatic t_restart();
    bit got;
    load_curves(0);
    set_cfg(1, 2, 1, 11, 40);
    run_engine(1, got);
    check(got, "R10 done seen", int'(got), 1);
    check_result("R10 restart ignored");
  endtask

  initial begin
    rst_n = 0; tbl_we = 0; tbl_kern = '0; tbl_cnt = '0; tbl_perf = '0;
    kern_res = '0; res_budget = '0; share_thresh = '0; start = 0;
    for (int k = 0; k < NK; k++) for (int c = 0; c <= NMAX; c++) tb_tbl[k][c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rising_cap();
    t_tie();
    t_budget();
    t_thresh();
    t_rewrite();
    t_restart();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end
endmodule